// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the main 16-bit control word of an Ethernet PHY, as seen from a serial management front end. The front end presents a 16-bit write value with a one-cycle write strobe and reads a 16-bit value back at any time. The stored bits drive the datapath controls: soft reset, loopback, link speed, duplex, power down, isolate, auto-negotiation enable and restart, and a collision test mode.

Two bits clear themselves only when other logic acknowledges them. The soft-reset bit clears when the reset sequencer reports completion. The restart bit clears when the negotiation engine reports that it has started. While auto-negotiation is enabled, the speed and duplex bits read back the values that negotiation chose, and those values also drive the speed and duplex outputs. In collision test mode the transmit enable input is looped onto the collision output.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A low `rst_n` at a clock edge loads the defaults: speed (bit 13) = 1, auto-negotiation enable (bit 12) = 1, duplex (bit 8) = 1, and bits 15, 14, 11, 10, 9 and 7 = 0.
- R2: A write with bit 15 set loads the defaults into every bit and sets bit 15. Bit 15 then reads 1 until `rst_done` is high at a clock edge, and reads 0 after that edge.
- R3: While bit 15 reads 1, writes are ignored.
- R4: A write with bits 12 and 9 both set raises the restart request (bit 9, `an_restart_o`). The request stays 1 until `an_started` is high at a clock edge, and reads 0 after that edge.
- R5: A write with bit 12 clear leaves bit 9 at 0: a set bit 9 in that write is ignored, and any pending restart request is dropped.
- R6: A write with bit 12 set and bit 9 clear does not cancel a pending restart request. Only `an_started` clears it.
- R7: While bit 12 is 1, read bits 13 and 8 and the outputs `speed_o` and `duplex_o` follow `an_speed` and `an_duplex`.
- R8: While bit 12 is 0, read bits 13 and 8 and the outputs `speed_o` and `duplex_o` return the last written bits 13 and 8 (1 = 100 Mbps, 1 = full duplex).
- R9: While bit 7 is 1, `col_out` equals `tx_en`. While bit 7 is 0, `col_out` equals `col_in`.
- R10: Bit 14 drives `loopback_o`, bit 11 drives `pwrdn_o` and bit 10 drives `isolate_o`. Each reads back as written, and register writes keep working while isolated.
- R11: Bits 6 to 0 always read 0, whatever was written to them.
- R12: A write takes effect only at a clock edge where `wr_en` is high. With `wr_en` low, the read value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the management front end |
| wr_data | input | 16 | Write value |
| rd_data | output | 16 | Read value |
| an_started | input | 1 | Negotiation engine reports that a restart has begun |
| an_speed | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_duplex | input | 1 | Negotiated duplex, 1 = full |
| rst_done | input | 1 | Reset sequencer reports completion |
| tx_en | input | 1 | Transmit enable from the MAC side |
| col_in | input | 1 | Normal collision indication |
| col_out | output | 1 | Collision output to the MAC side |
| soft_rst_o | output | 1 | Soft reset request |
| loopback_o | output | 1 | Loopback enable |
| speed_o | output | 1 | Effective link speed, 1 = 100 Mbps |
| duplex_o | output | 1 | Effective duplex, 1 = full |
| pwrdn_o | output | 1 | Power-down request |
| isolate_o | output | 1 | Disconnects the MII data interface |
| an_en_o | output | 1 | Auto-negotiation enable |
| an_restart_o | output | 1 | Auto-negotiation restart request |

## Verification
The bench builds the block with its default 16-bit register width, the only width at which the bit positions used by the management front end hold. At that width the bench reaches every control bit and all seven reserved bits. It also reaches the cases where a handshake and a write meet: a restart request that survives a write, a write blocked during a pending soft reset, and the negotiated speed and duplex replacing the stored bits as soon as bit 12 is set.

// File: rtl/phy_ctrl_pkg.sv
// Package: bit positions, the control-state type and the default and decode
// helpers shared by the control register and its submodules.
// Assumes a 16-bit management register with a fixed bit layout.
package phy_ctrl_pkg;

    localparam int REG_W   = 16;
    localparam int B_RST   = 15;
    localparam int B_LOOP  = 14;
    localparam int B_SPEED = 13;
    localparam int B_ANEN  = 12;
    localparam int B_PDN   = 11;
    localparam int B_ISO   = 10;
    localparam int B_RSTAN = 9;
    localparam int B_DUP   = 8;
    localparam int B_COLT  = 7;
    localparam int RSV_W   = B_COLT;   // bits below collision test are reserved

    typedef struct packed {
        logic soft_rst;
        logic loopback;
        logic speed;
        logic an_en;
        logic pwrdn;
        logic isolate;
        logic an_restart;
        logic duplex;
        logic col_test;
    } ctrl_t;

    // Default control state after either reset.
    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c        = '0;
        c.speed  = 1'b1;
        c.an_en  = 1'b1;
        c.duplex = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/phy_ctrl_store.sv
// Stored control bits with the self-clearing handshakes.
// Assumes wr_en is a single-cycle strobe. While a soft reset is pending the
// register is locked against writes until rst_done is seen.
module phy_ctrl_store
    import phy_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             an_started,
    input  logic             rst_done,
    output ctrl_t            q
);

    ctrl_t nxt;

    // Next-state selection: reset lock, soft reset, then normal write.
    always_comb begin
        nxt = q;
        if (q.soft_rst) begin
            if (rst_done) nxt.soft_rst = 1'b0;
        end else if (wr_en && wr_data[B_RST]) begin
            nxt          = ctrl_default();
            nxt.soft_rst = 1'b1;
        end else begin
            if (an_started) nxt.an_restart = 1'b0;
            if (wr_en) begin
                nxt.loopback = wr_data[B_LOOP];
                nxt.speed    = wr_data[B_SPEED];
                nxt.an_en    = wr_data[B_ANEN];
                nxt.pwrdn    = wr_data[B_PDN];
                nxt.isolate  = wr_data[B_ISO];
                nxt.duplex   = wr_data[B_DUP];
                nxt.col_test = wr_data[B_COLT];
                if (!wr_data[B_ANEN])
                    nxt.an_restart = 1'b0;
                else if (wr_data[B_RSTAN])
                    nxt.an_restart = 1'b1;
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ctrl_default();
        else        q <= nxt;
    end

endmodule

// File: rtl/phy_ctrl_view.sv
// Read-back and effective speed/duplex. While negotiation is enabled the
// negotiated values replace the stored speed and duplex bits.
// Assumes an_speed and an_duplex are already synchronous to clk.
module phy_ctrl_view
    import phy_ctrl_pkg::*;
(
    input  ctrl_t            q,
    input  logic             an_speed,
    input  logic             an_duplex,
    output logic [REG_W-1:0] rd_data,
    output logic             speed_eff,
    output logic             duplex_eff
);

    // Choose stored or negotiated speed and duplex.
    always_comb begin
        speed_eff  = q.an_en ? an_speed  : q.speed;
        duplex_eff = q.an_en ? an_duplex : q.duplex;
    end

    // Assemble the read word; reserved low bits read zero.
    always_comb begin
        rd_data            = '0;
        rd_data[B_RST]     = q.soft_rst;
        rd_data[B_LOOP]    = q.loopback;
        rd_data[B_SPEED]   = speed_eff;
        rd_data[B_ANEN]    = q.an_en;
        rd_data[B_PDN]     = q.pwrdn;
        rd_data[B_ISO]     = q.isolate;
        rd_data[B_RSTAN]   = q.an_restart;
        rd_data[B_DUP]     = duplex_eff;
        rd_data[B_COLT]    = q.col_test;
        rd_data[RSV_W-1:0] = '0;
    end

endmodule

// File: rtl/phy_col_path.sv
// Collision output select: in test mode transmit enable is looped back.
// Assumes all inputs are synchronous to the MAC-side clock; purely combinational.
module phy_col_path (
    input  logic col_test,
    input  logic tx_en,
    input  logic col_in,
    output logic col_out
);

    // Pick the collision source.
    always_comb col_out = col_test ? tx_en : col_in;

endmodule

// File: rtl/phy_ctrl_reg.sv
// Top level of the PHY basic control register: storage, read-back view and
// collision test path. Assumes one management write per strobe cycle.
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             an_started,
    input  logic             an_speed,
    input  logic             an_duplex,
    input  logic             rst_done,
    input  logic             tx_en,
    input  logic             col_in,
    output logic             col_out,
    output logic             soft_rst_o,
    output logic             loopback_o,
    output logic             speed_o,
    output logic             duplex_o,
    output logic             pwrdn_o,
    output logic             isolate_o,
    output logic             an_en_o,
    output logic             an_restart_o
);

    ctrl_t q;

    phy_ctrl_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .an_started (an_started),
        .rst_done   (rst_done),
        .q          (q)
    );

    phy_ctrl_view u_view (
        .q          (q),
        .an_speed   (an_speed),
        .an_duplex  (an_duplex),
        .rd_data    (rd_data),
        .speed_eff  (speed_o),
        .duplex_eff (duplex_o)
    );

    phy_col_path u_col (
        .col_test (q.col_test),
        .tx_en    (tx_en),
        .col_in   (col_in),
        .col_out  (col_out)
    );

    // Drive the plain control outputs from the stored state.
    always_comb begin
        soft_rst_o   = q.soft_rst;
        loopback_o   = q.loopback;
        pwrdn_o      = q.pwrdn;
        isolate_o    = q.isolate;
        an_en_o      = q.an_en;
        an_restart_o = q.an_restart;
    end

endmodule

// File: rtl/phy_ctrl_reg_chk.sv
// Checker for phy_ctrl_reg: port-level properties over time, bound to the top.
module phy_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        an_started,
    input logic        an_speed,
    input logic        an_duplex,
    input logic        rst_done,
    input logic        tx_en,
    input logic        col_out,
    input logic        soft_rst_o,
    input logic        loopback_o,
    input logic        speed_o,
    input logic        duplex_o,
    input logic        pwrdn_o,
    input logic        isolate_o,
    input logic        an_en_o,
    input logic        an_restart_o
);

    p_rst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o && !rst_done |=> soft_rst_o);

    p_rst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o && rst_done |=> !soft_rst_o);

    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o && wr_en |=> $stable(loopback_o) && $stable(pwrdn_o)
                                && $stable(isolate_o) && $stable(an_en_o));

    p_restart_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o && an_started && !wr_en |=> !an_restart_o);

    p_restart_needs_an_r5: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |-> an_en_o);

    p_restart_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o && !an_started && !soft_rst_o && (!wr_en || (wr_data[12] && !wr_data[15]))
        |=> an_restart_o);

    p_an_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        an_en_o |-> (speed_o == an_speed) && (duplex_o == an_duplex)
                    && (rd_data[13] == an_speed) && (rd_data[8] == an_duplex));

    p_col_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] |-> col_out == tx_en);

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'd0);

endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .an_started   (an_started),
    .an_speed     (an_speed),
    .an_duplex    (an_duplex),
    .rst_done     (rst_done),
    .tx_en        (tx_en),
    .col_out      (col_out),
    .soft_rst_o   (soft_rst_o),
    .loopback_o   (loopback_o),
    .speed_o      (speed_o),
    .duplex_o     (duplex_o),
    .pwrdn_o      (pwrdn_o),
    .isolate_o    (isolate_o),
    .an_en_o      (an_en_o),
    .an_restart_o (an_restart_o)
);

// File: tb/phy_ctrl_reg_bench.sv
// Bench for phy_ctrl_reg: a vector table of writes, then directed tests.
module phy_ctrl_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        an_started = 1'b0;
    logic        an_speed = 1'b0;
    logic        an_duplex = 1'b0;
    logic        rst_done = 1'b0;
    logic        tx_en = 1'b0;
    logic        col_in = 1'b0;
    logic        col_out, soft_rst_o, loopback_o, speed_o, duplex_o;
    logic        pwrdn_o, isolate_o, an_en_o, an_restart_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    phy_ctrl_reg u_phy_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .an_started(an_started), .an_speed(an_speed),
        .an_duplex(an_duplex), .rst_done(rst_done), .tx_en(tx_en),
        .col_in(col_in), .col_out(col_out), .soft_rst_o(soft_rst_o),
        .loopback_o(loopback_o), .speed_o(speed_o), .duplex_o(duplex_o),
        .pwrdn_o(pwrdn_o), .isolate_o(isolate_o), .an_en_o(an_en_o),
        .an_restart_o(an_restart_o)
    );

    // Row: {write value, an_speed, an_duplex, expected read,
    //       expected {loopback, pwrdn, isolate, an_en, restart, speed, duplex}}
    localparam int NV = 10;
    localparam logic [40:0] TBL [0:NV-1] = '{
        {16'h0000, 1'b0, 1'b0, 16'h0000, 7'b0000000},  // R8 all off
        {16'h2100, 1'b0, 1'b0, 16'h2100, 7'b0000011},  // R8 forced speed, duplex
        {16'h2000, 1'b0, 1'b1, 16'h2000, 7'b0000010},  // R8 ignores an_duplex
        {16'h1000, 1'b1, 1'b0, 16'h3000, 7'b0001010},  // R7 negotiated view
        {16'h1200, 1'b0, 1'b1, 16'h1300, 7'b0001101},  // R4 restart request
        {16'h0200, 1'b0, 1'b0, 16'h0000, 7'b0000000},  // R5 restart ignored, AN off
        {16'h4C00, 1'b0, 1'b0, 16'h4C00, 7'b1110000},  // R10 loop, pdn, isolate
        {16'h007F, 1'b1, 1'b1, 16'h0000, 7'b0000000},  // R11 reserved bits
        {16'h0080, 1'b0, 1'b0, 16'h0080, 7'b0000000},  // R9 collision test bit
        {16'h0100, 1'b0, 1'b0, 16'h0100, 7'b0000001}   // R8 duplex only
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [6:0] outs();
        return {loopback_o, pwrdn_o, isolate_o, an_en_o, an_restart_o, speed_o, duplex_o};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        an_speed  = 1'b1;
        an_duplex = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 read", rd_data, 16'h3000);
        chk("R1 outs", {9'd0, outs()}, {9'd0, 7'b0001010});
        chk("R1 soft_rst", {15'd0, soft_rst_o}, 16'd0);
        an_speed  = 1'b0;
        an_duplex = 1'b1;
        #1 chk("R1 read negotiated", rd_data, 16'h1100);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            an_speed  = TBL[i][24];
            an_duplex = TBL[i][23];
            wr(TBL[i][40:25]);
            chk($sformatf("table row %0d read", i), rd_data, TBL[i][22:7]);
            chk($sformatf("table row %0d outs", i), {9'd0, outs()}, {9'd0, TBL[i][6:0]});
        end

        // R12: no strobe, no change
        @(negedge clk);
        wr_data = 16'hFFFF;
        @(negedge clk);
        chk("R12 no strobe", rd_data, 16'h0100);

        // R9: collision loop
        wr(16'h0080);
        tx_en = 1'b1; col_in = 1'b0;
        #1 chk("R9 test tx=1", {15'd0, col_out}, 16'd1);
        tx_en = 1'b0; col_in = 1'b1;
        #1 chk("R9 test tx=0", {15'd0, col_out}, 16'd0);
        wr(16'h0000);
        #1 chk("R9 normal col=1", {15'd0, col_out}, 16'd1);
        tx_en = 1'b1; col_in = 1'b0;
        #1 chk("R9 normal col=0", {15'd0, col_out}, 16'd0);
        tx_en = 1'b0;

        // R10: access while isolated
        wr(16'h0400);
        chk("R10 isolate", {15'd0, isolate_o}, 16'd1);
        wr(16'h0500);
        chk("R10 write while isolated", rd_data, 16'h0500);

        // R4: restart held until handshake
        an_speed = 1'b0; an_duplex = 1'b0;
        wr(16'h1200);
        repeat (3) @(negedge clk);
        chk("R4 held", rd_data, 16'h1200);
        an_started = 1'b1;
        @(negedge clk);
        an_started = 1'b0;
        chk("R4 cleared", rd_data, 16'h1000);
        chk("R4 output", {15'd0, an_restart_o}, 16'd0);

        // R6: writing 0 to bit 9 does not cancel
        wr(16'h1200);
        wr(16'h1000);
        chk("R6 sticky", {15'd0, an_restart_o}, 16'd1);
        an_started = 1'b1;
        @(negedge clk);
        an_started = 1'b0;
        chk("R6 handshake", {15'd0, an_restart_o}, 16'd0);

        // R5: disabling negotiation drops request
        wr(16'h1200);
        wr(16'h0200);
        chk("R5 dropped", rd_data, 16'h0000);

        // R2 / R3: soft reset
        wr(16'h0C80);
        an_speed = 1'b1; an_duplex = 1'b1;
        wr(16'h8000);
        chk("R2 pending read", rd_data, 16'hB100);
        chk("R2 outs", {9'd0, outs()}, {9'd0, 7'b0001011});
        wr(16'h4000);
        chk("R3 write ignored", rd_data, 16'hB100);
        chk("R3 loopback", {15'd0, loopback_o}, 16'd0);
        repeat (2) @(negedge clk);
        chk("R2 still pending", {15'd0, soft_rst_o}, 16'd1);
        rst_done = 1'b1;
        @(negedge clk);
        rst_done = 1'b0;
        chk("R2 cleared", rd_data, 16'h3100);
        wr(16'h4000);
        chk("R3 unlocked", rd_data, 16'h4000);

        done = 1'b1;
        finish_run();
    end

endmodule